// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Controller

This block is the central dynamic-scheduling controller for a small floating-point pipeline. Five functional units do the work, and none of them is pipelined. Decoded instructions arrive one at a time in program order. The controller moves each instruction through four phases: issue, operand read, execution and write-back.

The controller holds one status slot per functional unit. Each slot records the destination register, the two source registers, a producer tag for each source and a ready flag for each source. The controller also keeps a result-status table with one producer tag per architectural register. From this state it drives an issue stall, a per-unit operand-read grant and a per-unit write-back grant. There is no forwarding path and no renaming. A write-after-write conflict holds issue. A write-after-read conflict holds write-back.

The units themselves sit outside the block. Each one reports the end of its execution with a one-cycle `fu_done` pulse. Unit slots are fixed: slot 0 is integer/load, slots 1 and 2 are multipliers, slot 3 is the adder and slot 4 is the divider. Unit tags are the slot index plus one, and tag 0 means "no producer".

Top module: `sb_hazard_ctl`

## Requirements
- R1: An instruction issues only in program order, and only when a unit of its class is idle. The class code on `in_cls` is 0 for integer/load, 1 for multiply, 2 for add and 3 for divide. Of the idle units of that class, the lowest-numbered one is taken. `issue_unit` carries the tag (slot+1) of that unit in the issuing cycle and 0 in every other cycle.
- R2: An instruction does not issue while its destination register has a pending producer. A register's result-status tag changes only when that producer writes back or when a new instruction issues to that register.
- R3: At issue, each used source records the producer tag from the result-status table. A source with no producer, or with no use, is ready at once. If the producer writes back in the same cycle as the issue, the source is also ready at once.
- R4: A unit gets `read_grant` in the first cycle after issue in which both of its sources are ready. The grant comes at the earliest one cycle after the last producer's write-back, because there is no forwarding. Reading clears both ready flags.
- R5: A `fu_done` pulse from a unit that is executing makes that unit eligible for write-back from the next cycle on. After its write-back cycle the unit is idle and can accept a new issue in the following cycle.
- R6: A unit's write-back is held while any other busy unit has a ready, unread source that names the same register as that unit's destination.
- R7: At most one unit writes back per cycle, and the lowest-numbered eligible unit wins. The write-back frees the destination's result-status entry and readies every waiting source that named the writer.
- R8: During reset all units are idle, the result-status table is empty and `issue_stall`, `issue_unit`, `read_grant` and `wb_grant` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_cls | input | 2 | Unit class of the instruction |
| in_dst | input | 3 | Destination register |
| in_src_j | input | 3 | First source register |
| in_src_k | input | 3 | Second source register |
| in_use_j | input | 1 | First source is used |
| in_use_k | input | 1 | Second source is used |
| fu_done | input | 5 | Per-unit end-of-execution pulse |
| issue_stall | output | 1 | Presented instruction cannot issue this cycle |
| issue_unit | output | 3 | Tag of the unit receiving the issue, 0 if none |
| read_grant | output | 5 | Per-unit operand-read grant |
| wb_grant | output | 5 | Per-unit write-back grant (at most one bit) |

## Verification
The bench runs three programs and checks the exact cycle of every issue, read and write-back.

- **Structural stall:** a second load is presented while the integer unit is busy. A design that ignored unit occupancy would issue it early.
- **Write-after-write stall:** an add targets a register that a multiply has not yet written. A design that skipped this check would issue the add while the multiply is still pending.
- **Write-after-read hold:** an add must wait to write a register until a stalled divide has read it. A design that let the add write early would overwrite an operand the divide still needs.
- **Write-back priority:** two multipliers finish in the same cycle. Granting both, or granting the higher-numbered one first, shows up as a one-cycle shift.
- **Same-cycle issue and write-back:** an add issues in the very cycle its producer writes back. A design without that bypass would never see the source become ready and would never read.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NUM_FU = 5;
  localparam int SB_REGS   = 8;
  localparam int SB_TAG_W  = 3;
  localparam int SB_CLS_W  = 2;

  typedef enum logic [SB_CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } fu_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT_OPS,
    PH_EXEC,
    PH_WAIT_WB
  } phase_e;

  // Fixed unit mix: slot 0 integer/load, 1..2 multiply, 3 add, 4 divide.
  function automatic logic [SB_CLS_W-1:0] unit_class(int u);
    if (u == 0) return CLS_INT;
    if (u <= 2) return CLS_MUL;
    if (u == 3) return CLS_ADD;
    return CLS_DIV;
  endfunction

  function automatic logic [SB_TAG_W-1:0] tag_of(int u);
    return SB_TAG_W'(u + 1);
  endfunction
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
#(
  parameter int NUM_FU = SB_NUM_FU
) (
  input  logic                in_valid,
  input  logic [SB_CLS_W-1:0] in_cls,
  input  logic [NUM_FU-1:0]   busy,
  input  logic                dst_pending,
  output logic                fire,
  output logic                stall,
  output logic [NUM_FU-1:0]   sel,
  output logic [SB_TAG_W-1:0] sel_tag
);
  logic [NUM_FU-1:0] cand;
  logic              found;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_cand
    assign cand[u] = !busy[u] && (unit_class(u) == in_cls);
  end

  always_comb begin
    sel     = '0;
    sel_tag = '0;
    found   = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (cand[u] && !found) begin
        sel[u]  = 1'b1;
        sel_tag = tag_of(u);
        found   = 1'b1;
      end
    end
  end

  assign fire  = in_valid && found && !dst_pending;
  assign stall = in_valid && !fire;
endmodule

// File: rtl/sb_wb_pick.sv
module sb_wb_pick
  import sb_pkg::*;
#(
  parameter int NUM_FU = SB_NUM_FU
) (
  input  logic [NUM_FU-1:0]   req,
  output logic [NUM_FU-1:0]   grant,
  output logic                any,
  output logic [SB_TAG_W-1:0] win_tag
);
  always_comb begin
    grant   = '0;
    win_tag = '0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (req[u]) begin
        grant   = '0;
        grant[u] = 1'b1;
        win_tag = tag_of(u);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [REG_W-1:0]    in_dst,
  input  logic [REG_W-1:0]    in_src_j,
  input  logic [REG_W-1:0]    in_src_k,
  input  logic                in_use_j,
  input  logic                in_use_k,
  input  logic [SB_TAG_W-1:0] in_qj,
  input  logic [SB_TAG_W-1:0] in_qk,
  input  logic                bc_valid,
  input  logic [SB_TAG_W-1:0] bc_tag,
  input  logic                done,
  input  logic                wb_win,
  output logic                busy,
  output logic                rd_go,
  output logic                wb_ready,
  output logic [REG_W-1:0]    fi,
  output logic [REG_W-1:0]    fj,
  output logic [REG_W-1:0]    fk,
  output logic                rj_live,
  output logic                rk_live
);
  phase_e              phase;
  logic [SB_TAG_W-1:0] qj, qk;
  logic                rj, rk, uj, uk;

  assign busy     = (phase != PH_IDLE);
  assign rd_go    = (phase == PH_WAIT_OPS) && rj && rk;
  assign wb_ready = (phase == PH_WAIT_WB);
  assign rj_live  = uj && rj;
  assign rk_live  = uk && rk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      fi <= '0; fj <= '0; fk <= '0;
      qj <= '0; qk <= '0;
      rj <= 1'b0; rk <= 1'b0; uj <= 1'b0; uk <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (take) begin
          fi <= in_dst; fj <= in_src_j; fk <= in_src_k;
          uj <= in_use_j; uk <= in_use_k;
          qj <= in_qj; qk <= in_qk;
          rj <= (in_qj == '0);
          rk <= (in_qk == '0);
          phase <= PH_WAIT_OPS;
        end
        PH_WAIT_OPS: begin
          if (rd_go) begin
            rj <= 1'b0;
            rk <= 1'b0;
            phase <= PH_EXEC;
          end else begin
            if (bc_valid && qj != '0 && qj == bc_tag) begin
              rj <= 1'b1;
              qj <= '0;
            end
            if (bc_valid && qk != '0 && qk == bc_tag) begin
              rk <= 1'b1;
              qk <= '0;
            end
          end
        end
        PH_EXEC: if (done) phase <= PH_WAIT_WB;
        PH_WAIT_WB: if (wb_win) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_READ_ENTERS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (phase == PH_EXEC) && !rj && !rk); // R4
  AST_FREE_ONLY_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wb_win)); // R5
  AST_WIN_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    wb_win |-> wb_ready); // R6
endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl
  import sb_pkg::*;
#(
  parameter int REG_CNT = SB_REGS,
  parameter int NUM_FU  = SB_NUM_FU,
  localparam int REG_W  = $clog2(REG_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SB_CLS_W-1:0] in_cls,
  input  logic [REG_W-1:0]    in_dst,
  input  logic [REG_W-1:0]    in_src_j,
  input  logic [REG_W-1:0]    in_src_k,
  input  logic                in_use_j,
  input  logic                in_use_k,
  input  logic [NUM_FU-1:0]   fu_done,
  output logic                issue_stall,
  output logic [SB_TAG_W-1:0] issue_unit,
  output logic [NUM_FU-1:0]   read_grant,
  output logic [NUM_FU-1:0]   wb_grant
);
  logic [SB_TAG_W-1:0] rstat [REG_CNT];

  logic [NUM_FU-1:0]   busy, wb_ready, war_block, wb_elig, sel;
  logic [NUM_FU-1:0]   rj_live, rk_live;
  logic [REG_W-1:0]    fi [NUM_FU];
  logic [REG_W-1:0]    fj [NUM_FU];
  logic [REG_W-1:0]    fk [NUM_FU];
  logic                issue_fire, wb_any;
  logic [SB_TAG_W-1:0] sel_tag, wb_tag, qj_new, qk_new;
  logic [REG_W-1:0]    wb_dst;

  sb_issue_sel #(.NUM_FU(NUM_FU)) u_issue (
    .in_valid   (in_valid),
    .in_cls     (in_cls),
    .busy       (busy),
    .dst_pending(rstat[in_dst] != '0),
    .fire       (issue_fire),
    .stall      (issue_stall),
    .sel        (sel),
    .sel_tag    (sel_tag)
  );

  assign issue_unit = issue_fire ? sel_tag : '0;

  // Producer tags for the issuing instruction, with same-cycle write-back bypass.
  always_comb begin
    qj_new = in_use_j ? rstat[in_src_j] : '0;
    qk_new = in_use_k ? rstat[in_src_k] : '0;
    if (wb_any && qj_new == wb_tag) qj_new = '0;
    if (wb_any && qk_new == wb_tag) qk_new = '0;
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    sb_fu_slot #(.REG_W(REG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (issue_fire && sel[u]),
      .in_dst  (in_dst),
      .in_src_j(in_src_j),
      .in_src_k(in_src_k),
      .in_use_j(in_use_j),
      .in_use_k(in_use_k),
      .in_qj   (qj_new),
      .in_qk   (qk_new),
      .bc_valid(wb_any),
      .bc_tag  (wb_tag),
      .done    (fu_done[u]),
      .wb_win  (wb_grant[u]),
      .busy    (busy[u]),
      .rd_go   (read_grant[u]),
      .wb_ready(wb_ready[u]),
      .fi      (fi[u]),
      .fj      (fj[u]),
      .fk      (fk[u]),
      .rj_live (rj_live[u]),
      .rk_live (rk_live[u])
    );
  end

  // Write-after-read check: another unit still owes a read of this destination.
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_block[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && ((rj_live[f] && fj[f] == fi[u]) ||
                       (rk_live[f] && fk[f] == fi[u])))
          war_block[u] = 1'b1;
      end
    end
  end

  assign wb_elig = wb_ready & ~war_block;

  sb_wb_pick #(.NUM_FU(NUM_FU)) u_pick (
    .req    (wb_elig),
    .grant  (wb_grant),
    .any    (wb_any),
    .win_tag(wb_tag)
  );

  always_comb begin
    wb_dst = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (wb_grant[u]) wb_dst = fi[u];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < REG_CNT; r++) rstat[r] <= '0;
    end else begin
      if (wb_any) rstat[wb_dst] <= '0;
      if (issue_fire) rstat[in_dst] <= sel_tag;
    end
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant)); // R7
  AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> ((sel & busy) == '0)); // R1
  AST_WB_NO_WAR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_any |-> ((wb_grant & war_block) == '0)); // R6

  for (genvar r = 0; r < REG_CNT; r++) begin : g_rchk
    AST_RSTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rstat[r] != '0 && !(wb_any && wb_tag == rstat[r]))
        |=> rstat[r] == $past(rstat[r])); // R2
  end
endmodule

// File: tb/sb_hazard_ctl_bench.sv
module sb_hazard_ctl_bench;
  localparam int CLK_P = 10;
  localparam int NU    = 5;
  localparam int BIG   = 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [2:0] in_dst = '0, in_src_j = '0, in_src_k = '0;
  logic       in_use_j = 1'b0, in_use_k = 1'b0;
  logic [4:0] fu_done = '0;
  logic       issue_stall;
  logic [2:0] issue_unit;
  logic [4:0] read_grant, wb_grant;

  sb_hazard_ctl u_sb_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src_j(in_src_j), .in_src_k(in_src_k),
    .in_use_j(in_use_j), .in_use_k(in_use_k), .fu_done(fu_done),
    .issue_stall(issue_stall), .issue_unit(issue_unit),
    .read_grant(read_grant), .wb_grant(wb_grant)
  );

  always #(CLK_P / 2) clk = ~clk;

  typedef struct { int cls; int dst; int s1; int s2; int u1; int u2; } ins_t;
  typedef struct { int cyc; int iss; int utag; int rd; int wb; } exp_t;

  ins_t prog[8];
  int   n_ins;
  exp_t expq[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  function automatic int lat_of(int cls);
    case (cls)
      0: return 1;
      1: return 10;
      2: return 2;
      default: return 40;
    endcase
  endfunction

  function automatic int cls_of_unit(int u);
    return (u == 0) ? 0 : (u <= 2) ? 1 : (u == 3) ? 2 : 3;
  endfunction

  task automatic put(int i, int c, int d, int a, int b, int ua, int ub);
    prog[i] = '{cls: c, dst: d, s1: a, s2: b, u1: ua, u2: ub};
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  // Driver side: instruction-ordered reference model that queues the expected events.
  task automatic build_expect();
    int iss[8], rd[8], wb[8], un[8], pj[8], pk[8];
    int p = 0;
    int lastw = -1;
    for (int i = 0; i < 8; i++) begin
      iss[i] = BIG; rd[i] = BIG; wb[i] = BIG; un[i] = 0; pj[i] = -1; pk[i] = -1;
    end
    for (int k = 0; k < 4000; k++) begin
      exp_t it;
      int best = -1;
      int alldone = 1;
      it = '{cyc: k, iss: 0, utag: 0, rd: 0, wb: 0};
      for (int i = 0; i < p; i++) begin
        bit war = 0;
        if (!(iss[i] < k && rd[i] < k && wb[i] == BIG &&
              rd[i] + lat_of(prog[i].cls) < k)) continue;
        for (int j = 0; j < p; j++) begin
          if (j == i || !(iss[j] < k) || rd[j] < k) continue;
          if (prog[j].u1 != 0 && prog[j].s1 == prog[i].dst &&
              (pj[j] < 0 || wb[pj[j]] < k)) war = 1;
          if (prog[j].u2 != 0 && prog[j].s2 == prog[i].dst &&
              (pk[j] < 0 || wb[pk[j]] < k)) war = 1;
        end
        if (!war && (best < 0 || un[i] < un[best])) best = i;
      end
      if (best >= 0) begin
        wb[best] = k;
        it.wb = 1 << un[best];
        lastw = k;
      end
      for (int i = 0; i < p; i++) begin
        if (iss[i] < k && rd[i] == BIG &&
            (pj[i] < 0 || wb[pj[i]] < k) && (pk[i] < 0 || wb[pk[i]] < k)) begin
          rd[i] = k;
          it.rd |= 1 << un[i];
        end
      end
      if (p < n_ins) begin
        int fu = -1;
        bit waw = 0;
        for (int u = NU - 1; u >= 0; u--) begin
          bit free = (cls_of_unit(u) == prog[p].cls);
          for (int i = 0; i < p; i++)
            if (un[i] == u && iss[i] < k && wb[i] >= k) free = 0;
          if (free) fu = u;
        end
        for (int i = 0; i < p; i++)
          if (iss[i] < k && wb[i] >= k && prog[i].dst == prog[p].dst) waw = 1;
        if (fu >= 0 && !waw) begin
          iss[p] = k; un[p] = fu;
          for (int q = 0; q < p; q++) begin
            if (prog[p].u1 != 0 && prog[q].dst == prog[p].s1 && wb[q] >= k) pj[p] = q;
            if (prog[p].u2 != 0 && prog[q].dst == prog[p].s2 && wb[q] >= k) pk[p] = q;
          end
          it.iss = 1; it.utag = fu + 1;
          p++;
        end
      end
      expq.push_back(it);
      for (int i = 0; i < n_ins; i++) if (wb[i] == BIG) alldone = 0;
      if (alldone && k >= lastw + 3) break;
    end
  endtask

  // Monitor side: compares one cycle of port activity with the next queued item.
  task automatic monitor_cycle(int k);
    exp_t it = expq.pop_front();
    int act_iss = (in_valid && !issue_stall) ? 1 : 0;
    check(it.cyc == k, "R1", "queue order", it.cyc, k);
    check(act_iss == it.iss && int'(issue_unit) == it.utag,
          "R1,R2,R3", $sformatf("cycle %0d issue/unit", k),
          act_iss * 10 + int'(issue_unit), it.iss * 10 + it.utag);
    check(int'(read_grant) == it.rd, "R3,R4",
          $sformatf("cycle %0d read_grant", k), int'(read_grant), it.rd);
    check(int'(wb_grant) == it.wb, "R5,R6,R7",
          $sformatf("cycle %0d wb_grant", k), int'(wb_grant), it.wb);
  endtask

  task automatic run_prog();
    int p = 0;
    int tmr[NU];
    for (int u = 0; u < NU; u++) tmr[u] = 0;
    build_expect();
    rst_n = 1'b0; in_valid = 1'b0; fu_done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!issue_stall && issue_unit == 0 && read_grant == 0 && wb_grant == 0,
          "R8", "outputs in reset",
          int'({issue_stall, issue_unit, read_grant, wb_grant}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int k = 0; expq.size() > 0; k++) begin
      if (k > 0) begin
        @(posedge clk); #1;
      end
      for (int u = 0; u < NU; u++) begin
        fu_done[u] = 1'b0;
        if (tmr[u] > 0) begin
          tmr[u]--;
          fu_done[u] = (tmr[u] == 0);
        end
      end
      in_valid = (p < n_ins);
      if (p < n_ins) begin
        in_cls = 2'(prog[p].cls); in_dst = 3'(prog[p].dst);
        in_src_j = 3'(prog[p].s1); in_src_k = 3'(prog[p].s2);
        in_use_j = prog[p].u1 != 0; in_use_k = prog[p].u2 != 0;
      end
      @(negedge clk);
      monitor_cycle(k);
      if (in_valid && !issue_stall) p++;
      for (int u = 0; u < NU; u++)
        if (read_grant[u]) tmr[u] = lat_of(cls_of_unit(u));
    end
    in_valid = 1'b0;
  endtask

  initial begin
    // Program A: structural stall on loads, WAR hold of the final add on r6 (R6).
    n_ins = 6;
    put(0, 0, 6, 0, 0, 0, 0);
    put(1, 0, 2, 0, 0, 0, 0);
    put(2, 1, 0, 2, 4, 1, 1);
    put(3, 2, 7, 6, 2, 1, 1);
    put(4, 3, 1, 0, 6, 1, 1);
    put(5, 2, 6, 7, 2, 1, 1);
    run_prog();
    // Program B: WAW stall on r3 (R2), then chained reads (R4).
    n_ins = 4;
    put(0, 1, 3, 1, 2, 1, 1);
    put(1, 2, 3, 4, 5, 1, 1);
    put(2, 3, 5, 3, 3, 1, 1);
    put(3, 1, 4, 5, 0, 1, 0);
    run_prog();
    // Program C: same-cycle bypass (R3), write-back collision (R7), unit reuse (R5).
    n_ins = 5;
    put(0, 0, 0, 0, 0, 0, 0);
    put(1, 1, 1, 0, 0, 1, 1);
    put(2, 1, 2, 0, 0, 1, 1);
    put(3, 2, 3, 0, 0, 1, 1);
    put(4, 1, 4, 1, 2, 1, 1);
    run_prog();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule